// File: doc/BRIEF.md
# Flash command state machine

This block interprets the command writes that software issues to a parallel NOR-style flash model on a simple synchronous memory bus. Each write carries a command code or an argument in its low data byte. The block tracks the write-cycle phase of a multi-step sequence and the command that is currently latched. It keeps an 8-bit status byte whose error bits stay set until software clears them. It also decides what a read returns: array data, status, identifier words or query bytes.

Single-word program and sector erase act on a small on-chip storage array and complete in the cycle they are issued. Buffered-write data is not stored here. It is passed, one registered word per write, to a separate buffer engine, and that engine is then told to commit or to discard. There is no program or erase timing: every operation reports ready at once. A read returns its data one cycle after `rd_en`, masked to the access size.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in read-array mode: phase 0, latched command 0x00, status 0x80, and every array word reads 0xFFFFFFFF.
- R2: In phase 0, data 0xFF, 0xF0 or 0x00 selects read-array mode. A read then returns the array word at `addr`, keeping only the low 2^`acc_size` bytes and returning the upper bytes as zero.
- R3: In phase 0, data 0x50 sets the status to 0x00 and selects read-array mode.
- R4: Data 0x70 or 0x90 in phase 0 latches the command and leaves the phase at 0. Under 0x90, a read at `addr[7:0]` = 0 returns the manufacturer code, at 1 it returns the device code, and at any other offset it returns zero. The code is placed in every device lane.
- R5: Data 0x98 enters query mode, which only 0xFF leaves. Query bytes are placed one per device lane: offsets 0x10/0x11/0x12 give 0x51/0x52/0x59, 0x13 gives 0x01, 0x27 gives log2 of the array size in bytes, 0x2C gives 0x01, and every other offset gives 0.
- R6: While the latched command is 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8, a read returns the status byte in the low byte of each DEV_BYTES-wide lane that fits inside the access. All other bytes read as zero.
- R7: After 0x10 or 0x40, the next write stores its low 2^`acc_size` bytes into the word at `addr` and returns to phase 0 with status bit 7 set. If `wr_protect` is high, the array is left unchanged and status bit 4 is set instead.
- R8: Data 0x20 in phase 0 fills every word of the sector holding `addr` with ones in the same cycle and sets status bit 7. If `wr_protect` is high, the array is untouched and status bit 5 is set as well.
- R9: In phase 1 after an erase, 0xD0 returns to phase 0 with bit 7 set and status reads still selected. 0xFF selects read-array mode. Any other value is illegal.
- R10: In phase 1 after 0x60, 0xD0 or 0x01 returns to phase 0 with bit 7 set. Any other value selects read-array mode.
- R11: Data 0xE8 sets bit 7 and takes a count N (low lane of the next write). Each of the following N+1 writes is forwarded on `bw_wr`/`bw_addr`/`bw_data` one cycle later, unless `wr_protect` is high, in which case bit 4 is set. Then 0xD0 with bit 4 clear pulses `bw_commit`; anything else pulses `bw_abort` and selects read-array mode.
- R12: An unknown code in phase 0 (for example 0x33 or 0x28), or an illegal value in a later phase, forces phase 0 and command 0x00.
- R13: Status bits 4 and 5 stay set until a 0x50 command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_protect | input | 1 | Device is read-only |
| addr | input | ADDR_W | Word address of the access |
| acc_size | input | 2 | Access width, 2^n bytes |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data, command in the low byte |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W | Read data, one cycle after rd_en |
| rd_valid | output | 1 | rdata is valid |
| bw_wr | output | 1 | Buffered-write word to engine |
| bw_addr | output | ADDR_W | Address of forwarded word |
| bw_data | output | DATA_W | Forwarded word |
| bw_commit | output | 1 | Buffer engine: commit |
| bw_abort | output | 1 | Buffer engine: discard |

## Verification
The read side is driven by a vector table. It walks every read source (array, status, identifier, query) at word, half and byte sizes. This separates lane replication from access masking, and it separates each offset decode from the others. Program, erase and buffered-write sequences are each run with protection off and on, against a bench-side array model. Open, confirmed, cancelled and illegal terminations then show which sequence step moved the phase, touched storage or set a sticky bit. Sticky bits are read again after unrelated mode changes and after a clear, so that a clear can be told apart from a simple overwrite.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ARG     = 2'd1,
    PH_DATA    = 2'd2,
    PH_CONFIRM = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_STATUS,
    SRC_IDENT,
    SRC_QUERY
  } rd_src_t;

  localparam logic [7:0] OP_ARRAY0   = 8'h00;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_ERASE_B  = 8'h28;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_CLEAR    = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BUFWR    = 8'hE8;
  localparam logic [7:0] OP_ARRAY1   = 8'hF0;
  localparam logic [7:0] OP_ARRAY2   = 8'hFF;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_UNLOCK   = 8'h01;

  localparam int ST_READY = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR = 4;

  function automatic rd_src_t source_of(input logic [7:0] cmd);
    case (cmd)
      OP_PROG_A, OP_ERASE, OP_ERASE_B, OP_PROG_B,
      OP_CLEAR, OP_LOCK, OP_STAT, OP_BUFWR: return SRC_STATUS;
      OP_IDENT: return SRC_IDENT;
      OP_QUERY: return SRC_QUERY;
      default:  return SRC_ARRAY;
    endcase
  endfunction

  function automatic logic [7:0] query_byte(input logic [7:0] off,
                                            input logic [7:0] size_log2);
    case (off)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h01;
      8'h27:   return size_log2;
      8'h2C:   return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [63:0] low_bytes(input logic [1:0] sz);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < 8; b++)
      if (b < (1 << sz)) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int LANE_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_protect,
  input  logic [7:0]           code,
  input  logic [LANE_BITS-1:0] arg,
  output phase_t               phase_q,
  output logic [7:0]           cmd_q,
  output logic [7:0]           status_q,
  output logic                 ev_prog,
  output logic                 ev_erase,
  output logic                 ev_clear,
  output logic                 ev_err,
  output logic                 ev_fwd,
  output logic                 ev_commit,
  output logic                 ev_abort
);

  phase_t               phase_n;
  logic [7:0]           cmd_n;
  logic [7:0]           status_n;
  logic [LANE_BITS-1:0] count_q, count_n;
  logic                 to_array;

  always_comb begin
    phase_n   = phase_q;
    cmd_n     = cmd_q;
    status_n  = status_q;
    count_n   = count_q;
    ev_prog   = 1'b0;
    ev_erase  = 1'b0;
    ev_clear  = 1'b0;
    ev_err    = 1'b0;
    ev_fwd    = 1'b0;
    ev_commit = 1'b0;
    ev_abort  = 1'b0;
    to_array  = 1'b0;
    if (wr_en) begin
      unique case (phase_q)
        PH_IDLE: begin
          case (code)
            OP_ARRAY0, OP_ARRAY1, OP_ARRAY2: to_array = 1'b1;
            OP_CLEAR: begin
              status_n = 8'h00;
              ev_clear = 1'b1;
              to_array = 1'b1;
            end
            OP_STAT, OP_IDENT: cmd_n = code;
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              cmd_n   = code;
              phase_n = PH_ARG;
            end
            OP_ERASE: begin
              cmd_n    = code;
              phase_n  = PH_ARG;
              ev_erase = !wr_protect;
              if (wr_protect) status_n[ST_ERASE_ERR] = 1'b1;
              status_n[ST_READY] = 1'b1;
            end
            OP_BUFWR: begin
              cmd_n   = code;
              phase_n = PH_ARG;
              status_n[ST_READY] = 1'b1;
            end
            default: ev_err = 1'b1;
          endcase
        end
        PH_ARG: begin
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              ev_prog = !wr_protect;
              if (wr_protect) status_n[ST_PROG_ERR] = 1'b1;
              status_n[ST_READY] = 1'b1;
              phase_n = PH_IDLE;
            end
            OP_ERASE, OP_ERASE_B: begin
              if (code == OP_CONFIRM) begin
                phase_n = PH_IDLE;
                status_n[ST_READY] = 1'b1;
              end else if (code == OP_ARRAY2) to_array = 1'b1;
              else ev_err = 1'b1;
            end
            OP_BUFWR: begin
              count_n = arg;
              phase_n = PH_DATA;
            end
            OP_LOCK: begin
              if (code == OP_CONFIRM || code == OP_UNLOCK) begin
                phase_n = PH_IDLE;
                status_n[ST_READY] = 1'b1;
              end else to_array = 1'b1;
            end
            OP_QUERY: if (code == OP_ARRAY2) to_array = 1'b1;
            default: ev_err = 1'b1;
          endcase
        end
        PH_DATA: begin
          if (cmd_q == OP_BUFWR) begin
            ev_fwd = !wr_protect;
            if (wr_protect) status_n[ST_PROG_ERR] = 1'b1;
            status_n[ST_READY] = 1'b1;
            if (count_q == '0) phase_n = PH_CONFIRM;
            else count_n = count_q - 1'b1;
          end else ev_err = 1'b1;
        end
        PH_CONFIRM: begin
          if (cmd_q == OP_BUFWR && code == OP_CONFIRM && !status_q[ST_PROG_ERR]) begin
            ev_commit = 1'b1;
            phase_n   = PH_IDLE;
            status_n[ST_READY] = 1'b1;
          end else begin
            ev_abort = 1'b1;
            if (cmd_q == OP_BUFWR) to_array = 1'b1;
            else ev_err = 1'b1;
          end
        end
        default: ev_err = 1'b1;
      endcase
      if (to_array || ev_err) begin
        phase_n = PH_IDLE;
        cmd_n   = OP_ARRAY0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cmd_q    <= OP_ARRAY0;
      status_q <= 8'h80;
      count_q  <= '0;
    end else begin
      phase_q  <= phase_n;
      cmd_q    <= cmd_n;
      status_q <= status_n;
      count_q  <= count_n;
    end
  end

endmodule

// File: rtl/flash_store.sv
module flash_store #(
  parameter int DATA_W     = 32,
  parameter int WORDS      = 64,
  parameter int SECT_WORDS = 16,
  localparam int IDX_W     = $clog2(WORDS),
  localparam int SECT_SH   = $clog2(SECT_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic              erase,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bmask,
  output logic [DATA_W-1:0] rword
);

  logic [DATA_W-1:0] mem [WORDS];

  function automatic logic same_sector(input logic [IDX_W-1:0] a,
                                       input logic [IDX_W-1:0] b);
    return (a >> SECT_SH) == (b >> SECT_SH);
  endfunction

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [IDX_W-1:0] WIDX = IDX_W'(w);
    always_ff @(posedge clk) begin
      if (!rst_n) mem[w] <= '1;
      else if (erase && same_sector(WIDX, idx)) mem[w] <= '1;
      else if (prog && idx == WIDX) mem[w] <= (mem[w] & ~bmask) | (wdata & bmask);
    end
  end

  assign rword = mem[idx];

endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DEV_BYTES = 2,
  parameter logic [15:0] MANUF_ID  = 16'h0089,
  parameter logic [15:0] DEVICE_ID = 16'h0018,
  parameter logic [7:0]  SIZE_LOG2 = 8'd8,
  localparam int LANE_BITS = DEV_BYTES * 8,
  localparam int LANES     = DATA_W / LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        acc_size,
  input  logic [7:0]        cmd,
  input  logic [7:0]        status,
  input  logic [DATA_W-1:0] aword,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);

  logic [7:0]           off;
  logic [LANE_BITS-1:0] lane_val;
  logic [DATA_W-1:0]    pick;
  logic [DATA_W-1:0]    amask;
  logic [63:0]          m64;

  function automatic logic [DATA_W-1:0] spread(input logic [LANE_BITS-1:0] v,
                                               input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    r = '0;
    r[LANE_BITS-1:0] = v;
    for (int k = 1; k < LANES; k++)
      if ((k + 1) * DEV_BYTES <= (1 << sz)) r[k*LANE_BITS +: LANE_BITS] = v;
    return r;
  endfunction

  assign off   = addr[7:0];
  assign m64   = low_bytes(acc_size);
  assign amask = m64[DATA_W-1:0];

  always_comb begin
    lane_val = '0;
    pick     = aword;
    unique case (source_of(cmd))
      SRC_STATUS: begin
        lane_val = LANE_BITS'(status);
        pick     = spread(lane_val, acc_size);
      end
      SRC_IDENT: begin
        if (off == 8'h00)      lane_val = LANE_BITS'(MANUF_ID);
        else if (off == 8'h01) lane_val = LANE_BITS'(DEVICE_ID);
        pick = spread(lane_val, acc_size);
      end
      SRC_QUERY: begin
        lane_val = LANE_BITS'(query_byte(off, SIZE_LOG2));
        pick     = spread(lane_val, acc_size);
      end
      default: pick = aword;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= pick & amask;
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int DEV_BYTES  = 2,
  parameter int WORDS      = 64,
  parameter int SECT_WORDS = 16,
  parameter logic [15:0] MANUF_ID  = 16'h0089,
  parameter logic [15:0] DEVICE_ID = 16'h0018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_protect,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        acc_size,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              bw_wr,
  output logic [ADDR_W-1:0] bw_addr,
  output logic [DATA_W-1:0] bw_data,
  output logic              bw_commit,
  output logic              bw_abort
);

  localparam int LANE_BITS = DEV_BYTES * 8;
  localparam int IDX_W     = $clog2(WORDS);
  localparam logic [7:0] SIZE_LOG2 = 8'($clog2(WORDS * DATA_W / 8));

  phase_t            phase_q;
  logic [7:0]        cmd_q;
  logic [7:0]        status_q;
  logic              ev_prog, ev_erase, ev_clear, ev_err;
  logic              ev_fwd, ev_commit, ev_abort;
  logic [DATA_W-1:0] aword;
  logic [DATA_W-1:0] wmask;
  logic [63:0]       m64;

  assign m64   = low_bytes(acc_size);
  assign wmask = m64[DATA_W-1:0];

  flash_cmd_seq #(.LANE_BITS(LANE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_protect(wr_protect),
    .code(wdata[7:0]), .arg(wdata[LANE_BITS-1:0]),
    .phase_q(phase_q), .cmd_q(cmd_q), .status_q(status_q),
    .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_clear(ev_clear), .ev_err(ev_err),
    .ev_fwd(ev_fwd), .ev_commit(ev_commit), .ev_abort(ev_abort)
  );

  flash_store #(.DATA_W(DATA_W), .WORDS(WORDS), .SECT_WORDS(SECT_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .prog(ev_prog), .erase(ev_erase),
    .idx(addr[IDX_W-1:0]), .wdata(wdata), .bmask(wmask), .rword(aword)
  );

  flash_rd_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_BYTES(DEV_BYTES),
    .MANUF_ID(MANUF_ID), .DEVICE_ID(DEVICE_ID), .SIZE_LOG2(SIZE_LOG2)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .acc_size(acc_size),
    .cmd(cmd_q), .status(status_q), .aword(aword),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bw_wr     <= 1'b0;
      bw_addr   <= '0;
      bw_data   <= '0;
      bw_commit <= 1'b0;
      bw_abort  <= 1'b0;
    end else begin
      bw_wr     <= ev_fwd;
      bw_commit <= ev_commit;
      bw_abort  <= ev_abort;
      if (ev_fwd) begin
        bw_addr <= addr;
        bw_data <= wdata;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic [7:0] cmd,
  input logic [7:0] status,
  input logic       ev_prog,
  input logic       ev_erase,
  input logic       ev_clear,
  input logic       ev_err,
  input logic       ev_commit,
  input logic       bw_commit
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (status == 8'h80 && phase == 2'd0 && cmd == 8'h00));

  // R12
  illegal_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> (phase == 2'd0 && cmd == 8'h00));

  // R13
  sticky_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> $past(ev_clear));

  // R13
  sticky_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[5]) |-> $past(ev_clear));

  // R8
  erase_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_erase |=> (status[7] && phase == 2'd1));

  // R7
  prog_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> (phase == 2'd0 && status[7]));

  // R11
  commit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |-> !status[4]);

  // R11
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> bw_commit);

endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase_q), .cmd(cmd_q), .status(status_q),
  .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_clear(ev_clear), .ev_err(ev_err),
  .ev_commit(ev_commit), .bw_commit(bw_commit)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_protect = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  acc_size = 2'd2;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic        bw_wr;
  logic [7:0]  bw_addr;
  logic [31:0] bw_data;
  logic        bw_commit, bw_abort;

  int errors = 0;
  int checks = 0;
  int n_fwd = 0, n_commit = 0, n_abort = 0;
  logic [7:0]  last_addr;
  logic [31:0] last_data;
  logic [31:0] mdl [64];
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_protect(wr_protect), .addr(addr),
    .acc_size(acc_size), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .rd_valid(rd_valid), .bw_wr(bw_wr), .bw_addr(bw_addr),
    .bw_data(bw_data), .bw_commit(bw_commit), .bw_abort(bw_abort)
  );

  always @(negedge clk) begin
    if (bw_wr) begin
      n_fwd++;
      last_addr = bw_addr;
      last_data = bw_data;
    end
    if (bw_commit) n_commit++;
    if (bw_abort) n_abort++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    addr = a; wdata = d; acc_size = sz; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [1:0] sz,
                    input logic [31:0] exp);
    @(negedge clk);
    addr = a; acc_size = sz; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rd_valid ? rdata : 32'hDEAD_BEEF, exp);
  endtask

  // {req, op(0 wr,1 rd), size, addr, data, expected}
  localparam int NV = 39;
  localparam logic [79:0] VEC [NV] = '{
    {4'd1,  2'd1, 2'd2, 8'h00, 32'h0,  32'hFFFFFFFF}, // R1
    {4'd6,  2'd0, 2'd2, 8'h00, 32'h70, 32'h0},
    {4'd6,  2'd1, 2'd2, 8'h00, 32'h0,  32'h00800080}, // R6
    {4'd6,  2'd1, 2'd0, 8'h00, 32'h0,  32'h00000080},
    {4'd4,  2'd0, 2'd2, 8'h00, 32'h90, 32'h0},
    {4'd4,  2'd1, 2'd2, 8'h00, 32'h0,  32'h00890089}, // R4
    {4'd4,  2'd1, 2'd2, 8'h01, 32'h0,  32'h00180018},
    {4'd4,  2'd1, 2'd2, 8'h02, 32'h0,  32'h00000000},
    {4'd4,  2'd1, 2'd1, 8'h01, 32'h0,  32'h00000018},
    {4'd2,  2'd0, 2'd2, 8'h00, 32'hF0, 32'h0},
    {4'd2,  2'd1, 2'd2, 8'h00, 32'h0,  32'hFFFFFFFF}, // R2
    {4'd5,  2'd0, 2'd2, 8'h00, 32'h98, 32'h0},
    {4'd5,  2'd1, 2'd2, 8'h10, 32'h0,  32'h00510051}, // R5
    {4'd5,  2'd1, 2'd2, 8'h11, 32'h0,  32'h00520052},
    {4'd5,  2'd1, 2'd2, 8'h12, 32'h0,  32'h00590059},
    {4'd5,  2'd1, 2'd2, 8'h27, 32'h0,  32'h00080008},
    {4'd5,  2'd1, 2'd2, 8'h2C, 32'h0,  32'h00010001},
    {4'd5,  2'd1, 2'd2, 8'h05, 32'h0,  32'h00000000},
    {4'd5,  2'd0, 2'd2, 8'h00, 32'h55, 32'h0},
    {4'd5,  2'd1, 2'd2, 8'h13, 32'h0,  32'h00010001},
    {4'd2,  2'd0, 2'd2, 8'h00, 32'hFF, 32'h0},
    {4'd2,  2'd1, 2'd2, 8'h00, 32'h0,  32'hFFFFFFFF},
    {4'd3,  2'd0, 2'd2, 8'h00, 32'h50, 32'h0},
    {4'd3,  2'd0, 2'd2, 8'h00, 32'h70, 32'h0},
    {4'd3,  2'd1, 2'd2, 8'h00, 32'h0,  32'h00000000}, // R3
    {4'd10, 2'd0, 2'd2, 8'h00, 32'h60, 32'h0},
    {4'd6,  2'd1, 2'd2, 8'h00, 32'h0,  32'h00000000},
    {4'd10, 2'd0, 2'd2, 8'h00, 32'h01, 32'h0},
    {4'd10, 2'd1, 2'd2, 8'h00, 32'h0,  32'h00800080}, // R10
    {4'd10, 2'd0, 2'd2, 8'h00, 32'h60, 32'h0},
    {4'd10, 2'd0, 2'd2, 8'h00, 32'h42, 32'h0},
    {4'd10, 2'd1, 2'd2, 8'h00, 32'h0,  32'hFFFFFFFF},
    {4'd12, 2'd0, 2'd2, 8'h00, 32'h70, 32'h0},
    {4'd12, 2'd0, 2'd2, 8'h00, 32'h33, 32'h0},
    {4'd12, 2'd1, 2'd2, 8'h00, 32'h0,  32'hFFFFFFFF}, // R12
    {4'd12, 2'd0, 2'd2, 8'h00, 32'h28, 32'h0},
    {4'd12, 2'd1, 2'd2, 8'h00, 32'h0,  32'hFFFFFFFF},
    {4'd2,  2'd0, 2'd2, 8'h00, 32'h00, 32'h0},
    {4'd2,  2'd1, 2'd0, 8'h00, 32'h0,  32'h000000FF}
  };

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      v = VEC[i];
      if (v[75:74] == 2'd0) wr(v[71:64], v[63:32], v[73:72]);
      else rd($sformatf("R%0d vec %0d", v[79:76], i), v[71:64], v[73:72], v[31:0]);
    end

    // R7 program, full word then a single byte
    wr(8'd3, 32'h40); wr(8'd3, 32'h12345678, 2'd2); mdl[3] = 32'h12345678;
    rd("R7 status after program", 8'd0, 2'd2, 32'h00800080);
    wr(8'd0, 32'hFF);
    rd("R7 word written", 8'd3, 2'd2, mdl[3]);
    wr(8'd5, 32'h10); wr(8'd5, 32'h0000CDAB, 2'd0); mdl[5] = 32'hFFFFFFAB;
    wr(8'd0, 32'hFF);
    rd("R7 byte write", 8'd5, 2'd2, mdl[5]);
    wr(8'd0, 32'h40); wr(8'd0, 32'h11111111); mdl[0] = 32'h11111111;
    wr(8'd20, 32'h40); wr(8'd20, 32'hA5A5A5A5); mdl[20] = 32'hA5A5A5A5;

    // R8 / R9 erase of sector 1 (words 16..31), confirmed
    wr(8'h13, 32'h20);
    for (int w = 16; w < 32; w++) mdl[w] = 32'hFFFFFFFF;
    rd("R8 status during erase", 8'd0, 2'd2, 32'h00800080);
    wr(8'h13, 32'hD0);
    rd("R9 confirm keeps status reads", 8'd0, 2'd2, 32'h00800080);
    wr(8'd0, 32'hFF);
    rd("R8 sector erased", 8'd20, 2'd2, mdl[20]);
    rd("R8 other sector kept", 8'd3, 2'd2, mdl[3]);
    wr(8'h30, 32'h20); wr(8'h30, 32'hFF);
    rd("R9 FF after erase gives array", 8'd0, 2'd2, mdl[0]);
    wr(8'h30, 32'h20); wr(8'h30, 32'h77);
    rd("R9 illegal after erase gives array", 8'd5, 2'd2, mdl[5]);

    // R7 / R8 / R13 with protection
    wr_protect = 1'b1;
    wr(8'd3, 32'h40); wr(8'd3, 32'h0BADF00D);
    rd("R7 protected program status", 8'd0, 2'd2, 32'h00900090);
    wr(8'd0, 32'hFF);
    rd("R7 protected word unchanged", 8'd3, 2'd2, mdl[3]);
    wr(8'd0, 32'h20);
    rd("R8 protected erase status", 8'd0, 2'd2, 32'h00B000B0);
    wr(8'd0, 32'hD0); wr(8'd0, 32'hFF);
    rd("R8 protected sector kept", 8'd0, 2'd2, mdl[0]);
    wr(8'd0, 32'h70);
    rd("R13 error bits sticky", 8'd0, 2'd2, 32'h00B000B0);
    wr(8'd0, 32'h50); wr(8'd0, 32'h70);
    rd("R13 cleared by 0x50", 8'd0, 2'd2, 32'h00000000);
    wr_protect = 1'b0;

    // R11 buffered write, committed
    wr(8'd8, 32'hE8);
    rd("R11 status after E8", 8'd0, 2'd2, 32'h00800080);
    wr(8'd8, 32'h2);
    wr(8'd8, 32'hAAAA0001); wr(8'd9, 32'hAAAA0002); wr(8'd10, 32'hAAAA0003);
    wr(8'd8, 32'hD0);
    @(negedge clk);
    check("R11 words forwarded", 32'(n_fwd), 32'd3);
    check("R11 last address", 32'(last_addr), 32'd10);
    check("R11 last data", last_data, 32'hAAAA0003);
    check("R11 commit count", 32'(n_commit), 32'd1);
    check("R11 no abort", 32'(n_abort), 32'd0);
    // cancelled
    wr(8'd0, 32'hE8); wr(8'd0, 32'h0); wr(8'd0, 32'h55); wr(8'd0, 32'h11);
    @(negedge clk);
    check("R11 abort on bad confirm", 32'(n_abort), 32'd1);
    rd("R11 abort gives array", 8'd0, 2'd2, mdl[0]);
    // protected
    wr_protect = 1'b1;
    wr(8'd0, 32'hE8); wr(8'd0, 32'h0); wr(8'd0, 32'h99); wr(8'd0, 32'hD0);
    @(negedge clk);
    wr_protect = 1'b0;
    check("R11 protected nothing forwarded", 32'(n_fwd), 32'd5 - 32'd1);
    check("R11 protected confirm aborts", 32'(n_abort), 32'd2);
    check("R11 commit not repeated", 32'(n_commit), 32'd1);
    wr(8'd0, 32'h70);
    rd("R13 prog error after buffer", 8'd0, 2'd2, 32'h00900090);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule